// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block decides, cycle by cycle, which parts of a multi-source clock generator may run and which clock outputs may drive their pads. It watches two active-low pins: a shutdown/output-enable pin and a suspend pin that also serves as a frequency-select bit elsewhere in the chip. Static configuration bits shape what each pin does. The block drives an enable for each PLL, an enable for the reference oscillator and its counters, an output enable for each configurable clock output, and a one-cycle request to restart PLL locking.

A low on the shutdown pin always takes the clock outputs off their pads. When the shutdown option is set, the same low also stops every PLL and the reference oscillator. When the option is clear, only the outputs are taken off. A low on the suspend pin, when the suspend option is set, stops the PLLs and the outputs chosen by two masks. An output fed by a stopped PLL is always stopped, whatever its own mask bit says. Each output's source is a configuration input. After a PLL is started again, the outputs it feeds stay disabled until a lock-wait counter of `LOCK_CYCLES` clocks has run out. A disabled output reads as logic low.

Top module: `clkpm_ctrl`

## Requirements
- R1: While `rst` is high, `pll_en`, `ref_en`, `out_oe`, `out_pad` and `relock_pulse` are all 0.
- R2: After reset, with both pins high, every PLL is enabled and the reference is enabled. Every output is enabled once the lock wait has run out.
- R3: With `cfg_shdn_en`=1, a low on `shdn_oe_n` drives `pll_en`, `ref_en` and `out_oe` to all zeros.
- R4: With `cfg_shdn_en`=0, a low on `shdn_oe_n` clears only `out_oe`, and `pll_en` and `ref_en` stay 1. When the pin is released, the outputs return within 3 clocks and no lock wait takes place.
- R5: When a full shutdown ends, `relock_pulse` is high for exactly one cycle. Outputs sourced from the reference are enabled at once. Outputs sourced from a PLL stay disabled until that PLL's lock counter of `LOCK_CYCLES` clocks has run out.
- R6: With `cfg_susp_en`=0, the `susp_n` pin has no effect on any output.
- R7: With `cfg_susp_en`=1 and `susp_n` low, each PLL p with `cfg_pll_susp[p]`=1 is disabled. Each output o with `cfg_out_susp[o]`=1 is disabled.
- R8: Source code `cfg_out_src[o*SRC_W +: SRC_W]` selects the source of output o: 0 means the reference and k means PLL k-1. While suspend is active, an output whose source PLL is suspended is disabled even if its own mask bit is 0.
- R9: When suspend ends, outputs disabled only by their own mask return within 3 clocks. Outputs fed by a suspended PLL wait for that PLL's lock counter.
- R10: Shutdown has priority over suspend. During a full shutdown everything is off even if suspend is also active. When the shutdown ends while suspend is still active, the suspend masks apply.
- R11: `out_pad[o]` equals `out_raw[o]` while `out_oe[o]` is 1, and reads 0 while `out_oe[o]` is 0.
- R12: Both pins pass through a two-flop synchronizer. A pin change shows on the outputs after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_oe_n | input | 1 | Active-low shutdown / output-enable pin |
| susp_n | input | 1 | Active-low suspend pin (shared with a select bit) |
| cfg_shdn_en | input | 1 | 1: the shutdown pin also stops the PLLs and the reference |
| cfg_susp_en | input | 1 | 1: the suspend pin is honoured |
| cfg_pll_susp | input | NUM_PLL | PLLs stopped during suspend |
| cfg_out_susp | input | NUM_OUT | Outputs disabled during suspend |
| cfg_out_src | input | NUM_OUT*SRC_W | Source code per output (0 = reference, k = PLL k-1) |
| out_raw | input | NUM_OUT | Clock value offered to each output pad |
| pll_en | output | NUM_PLL | Run enable per PLL |
| ref_en | output | 1 | Reference oscillator and counter enable |
| out_oe | output | NUM_OUT | Output drive enable per clock output |
| out_pad | output | NUM_OUT | Gated output value, 0 when disabled |
| relock_pulse | output | 1 | One-cycle request to relock after a full shutdown |

## Verification
Assertions check four things on every cycle. No enabled output may draw from a disabled PLL. A disabled reference forces all outputs off. A full shutdown clears every enable on the next cycle. A lock counter never reports lock in the cycle its PLL starts. The bench scenarios show the rest. They show the exact three-edge latency of the synchronizer and the difference between full and output-only shutdown. They show the suspend masks widened by source assignment, and that suspend is ignored when its option is off. They show the staggered return, where reference outputs come back at once and PLL outputs come back only after the lock wait.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  // Source code 0 selects the reference; code k selects PLL k-1.
  localparam int SRC_REF = 0;

  function automatic int src_width(input int num_pll);
    return (num_pll + 1 > 2) ? $clog2(num_pll + 1) : 1;
  endfunction
endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RESET_VAL}};
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/clkpm_lock_timer.sv
module clkpm_lock_timer #(
  parameter int LOCK_CYCLES = 64,
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic locked
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYCLES);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign locked = run && (cnt_q == '0);

  // R5
  lock_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> !locked);
endmodule

// File: rtl/clkpm_out_gate.sv
module clkpm_out_gate #(
  parameter int NUM_PLL = 3,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shdn_act,
  input  logic               susp_act,
  input  logic               out_mask,
  input  logic [SRC_W-1:0]   src,
  input  logic [NUM_PLL-1:0] pll_susp,
  input  logic [NUM_PLL-1:0] pll_locked,
  input  logic               ref_ok,
  input  logic               raw,
  output logic               oe,
  output logic               pad
);
  logic src_valid;
  logic src_susp;

  always_comb begin
    src_valid = (src == SRC_W'(clkpm_pkg::SRC_REF)) ? ref_ok : 1'b0;
    src_susp  = 1'b0;
    for (int p = 0; p < NUM_PLL; p++) begin
      if (src == SRC_W'(p + 1)) begin
        src_valid = pll_locked[p];
        src_susp  = pll_susp[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= !shdn_act && !(susp_act && (out_mask || src_susp)) && src_valid;
  end

  assign pad = oe & raw;
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl #(
  parameter int NUM_PLL     = 3,
  parameter int NUM_OUT     = 6,
  parameter int LOCK_CYCLES = 64,
  localparam int SRC_W = clkpm_pkg::src_width(NUM_PLL)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shdn_oe_n,
  input  logic                     susp_n,
  input  logic                     cfg_shdn_en,
  input  logic                     cfg_susp_en,
  input  logic [NUM_PLL-1:0]       cfg_pll_susp,
  input  logic [NUM_OUT-1:0]       cfg_out_susp,
  input  logic [NUM_OUT*SRC_W-1:0] cfg_out_src,
  input  logic [NUM_OUT-1:0]       out_raw,
  output logic [NUM_PLL-1:0]       pll_en,
  output logic                     ref_en,
  output logic [NUM_OUT-1:0]       out_oe,
  output logic [NUM_OUT-1:0]       out_pad,
  output logic                     relock_pulse
);
  logic [1:0]         pins_s;
  logic               shdn_act, shdn_full, susp_act, shdn_full_q;
  logic [NUM_PLL-1:0] pll_run, pll_locked;

  clkpm_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din({susp_n, shdn_oe_n}), .dout(pins_s));

  assign shdn_act  = !pins_s[0];
  assign shdn_full = shdn_act && cfg_shdn_en;
  assign susp_act  = cfg_susp_en && !pins_s[1];

  genvar p, o;
  generate
    for (p = 0; p < NUM_PLL; p++) begin : g_pll
      assign pll_run[p] = !shdn_full && !(susp_act && cfg_pll_susp[p]);
      clkpm_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .run(pll_run[p]), .locked(pll_locked[p]));
    end

    for (o = 0; o < NUM_OUT; o++) begin : g_out
      clkpm_out_gate #(.NUM_PLL(NUM_PLL), .SRC_W(SRC_W)) u_gate (
        .clk(clk), .rst(rst), .shdn_act(shdn_act), .susp_act(susp_act),
        .out_mask(cfg_out_susp[o]), .src(cfg_out_src[o*SRC_W +: SRC_W]),
        .pll_susp(susp_act ? cfg_pll_susp : '0), .pll_locked(pll_locked),
        .ref_ok(!shdn_full), .raw(out_raw[o]), .oe(out_oe[o]), .pad(out_pad[o]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en       <= '0;
      ref_en       <= 1'b0;
      shdn_full_q  <= 1'b0;
      relock_pulse <= 1'b0;
    end else begin
      pll_en       <= pll_run;
      ref_en       <= !shdn_full;
      shdn_full_q  <= shdn_full;
      relock_pulse <= shdn_full_q && !shdn_full;
    end
  end

  // R3
  shdn_full_chk: assert property (@(posedge clk) disable iff (rst)
    shdn_full |=> (pll_en == '0 && !ref_en));

  // R3
  ref_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_en |-> (out_oe == '0));

  // R5
  relock_once_chk: assert property (@(posedge clk) disable iff (rst)
    relock_pulse |=> !relock_pulse);

  generate
    for (o = 0; o < NUM_OUT; o++) begin : g_chk_o
      for (p = 0; p < NUM_PLL; p++) begin : g_chk_p
        // R8
        src_off_chk: assert property (@(posedge clk) disable iff (rst)
          (out_oe[o] && cfg_out_src[o*SRC_W +: SRC_W] == SRC_W'(p + 1)) |-> pll_en[p]);
      end
    end
  endgenerate
endmodule

// File: tb/clkpm_ctrl_test.sv
module clkpm_ctrl_test;
  localparam int NP = 3, NO = 6, LK = 20, SW = 2;

  logic clk = 0, rst = 1;
  logic shdn_oe_n = 1, susp_n = 1, cfg_shdn_en = 1, cfg_susp_en = 0;
  logic [NP-1:0] cfg_pll_susp = '0;
  logic [NO-1:0] cfg_out_susp = '0;
  // out5..out0 sources: PLL2, PLL0, PLL2, PLL1, PLL0, ref
  logic [NO*SW-1:0] cfg_out_src = {2'd3, 2'd1, 2'd3, 2'd2, 2'd1, 2'd0};
  logic [NO-1:0] out_raw = '1;
  logic [NP-1:0] pll_en;
  logic ref_en, relock_pulse;
  logic [NO-1:0] out_oe, out_pad;

  clkpm_ctrl #(.NUM_PLL(NP), .NUM_OUT(NO), .LOCK_CYCLES(LK)) uut (
    .clk(clk), .rst(rst), .shdn_oe_n(shdn_oe_n), .susp_n(susp_n),
    .cfg_shdn_en(cfg_shdn_en), .cfg_susp_en(cfg_susp_en),
    .cfg_pll_susp(cfg_pll_susp), .cfg_out_susp(cfg_out_susp),
    .cfg_out_src(cfg_out_src), .out_raw(out_raw), .pll_en(pll_en),
    .ref_en(ref_en), .out_oe(out_oe), .out_pad(out_pad),
    .relock_pulse(relock_pulse));

  always #5 clk = ~clk;

  typedef struct {
    string         req;
    logic [NP-1:0] pll;
    logic          rf;
    logic [NO-1:0] oe;
    logic          relk;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, relock_cnt = 0;
  bit done = 0;

  always @(negedge clk) if (relock_pulse) relock_cnt++;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input logic [NP-1:0] pll,
                              input logic rf, input logic [NO-1:0] oe);
    exp_t e;
    e.req = req; e.pll = pll; e.rf = rf; e.oe = oe; e.relk = 1'b0;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic check_count(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s relock pulses: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pop each expected item and compare against the ports.
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if (pll_en !== e.pll || ref_en !== e.rf || out_oe !== e.oe ||
          out_pad !== (e.oe & out_raw) || (e.req == "R1" && relock_pulse !== 1'b0)) begin
        errors++;
        $display("FAIL %s: actual pll=%b ref=%b oe=%b pad=%b expected pll=%b ref=%b oe=%b pad=%b",
                 e.req, pll_en, ref_en, out_oe, out_pad, e.pll, e.rf, e.oe, e.oe & out_raw);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    expect_state("R1", 3'b000, 1'b0, 6'b000000);
    rst = 0;
    wait_cyc(40);
    expect_state("R2", 3'b111, 1'b1, 6'b111111);

    // R12 latency and R3 full shutdown
    shdn_oe_n = 0;
    wait_cyc(2);
    expect_state("R12", 3'b111, 1'b1, 6'b111111);
    wait_cyc(1);
    expect_state("R3", 3'b000, 1'b0, 6'b000000);
    wait_cyc(5);
    relock_cnt = 0;
    shdn_oe_n = 1;
    wait_cyc(6);
    expect_state("R5", 3'b111, 1'b1, 6'b000001);
    wait_cyc(30);
    expect_state("R5", 3'b111, 1'b1, 6'b111111);
    check_count("R5", relock_cnt, 1);

    // R4 output-only shutdown
    cfg_shdn_en = 0;
    relock_cnt = 0;
    shdn_oe_n = 0;
    wait_cyc(6);
    expect_state("R4", 3'b111, 1'b1, 6'b000000);
    shdn_oe_n = 1;
    wait_cyc(3);
    expect_state("R4", 3'b111, 1'b1, 6'b111111);
    check_count("R4", relock_cnt, 0);
    cfg_shdn_en = 1;

    // R11 pad follows raw while enabled
    out_raw = 6'b010110;
    wait_cyc(1);
    expect_state("R11", 3'b111, 1'b1, 6'b111111);
    out_raw = '1;

    // R6 suspend option off
    cfg_pll_susp = 3'b111; cfg_out_susp = 6'b111111;
    susp_n = 0;
    wait_cyc(6);
    expect_state("R6", 3'b111, 1'b1, 6'b111111);
    susp_n = 1;
    wait_cyc(4);

    // R7 suspend masks
    cfg_susp_en = 1; cfg_pll_susp = 3'b010; cfg_out_susp = 6'b000001;
    susp_n = 0;
    wait_cyc(6);
    expect_state("R7", 3'b101, 1'b1, 6'b111010);
    susp_n = 1;
    wait_cyc(30);
    expect_state("R9", 3'b111, 1'b1, 6'b111111);

    // R8 derived suspend through source assignment
    cfg_pll_susp = 3'b001; cfg_out_susp = 6'b001000;
    susp_n = 0;
    wait_cyc(6);
    expect_state("R8", 3'b110, 1'b1, 6'b100101);
    susp_n = 1;
    wait_cyc(6);
    expect_state("R9", 3'b111, 1'b1, 6'b101101);
    wait_cyc(30);
    expect_state("R9", 3'b111, 1'b1, 6'b111111);

    // R10 shutdown over suspend
    susp_n = 0;
    wait_cyc(6);
    expect_state("R10", 3'b110, 1'b1, 6'b100101);
    shdn_oe_n = 0;
    wait_cyc(6);
    expect_state("R10", 3'b000, 1'b0, 6'b000000);
    shdn_oe_n = 1;
    wait_cyc(6);
    expect_state("R10", 3'b110, 1'b1, 6'b000001);
    wait_cyc(30);
    expect_state("R10", 3'b110, 1'b1, 6'b100101);
    susp_n = 1;
    wait_cyc(30);
    expect_state("R2", 3'b111, 1'b1, 6'b111111);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule